// File: doc/BRIEF.md
# Serial EEPROM Port Arbiter

This block lets software reach an external one-bit serial EEPROM through a small byte-wide control register. The EEPROM sits on a memory port that another requester also uses. Software sets a request bit in the register. The arbiter takes the port as soon as the other requester reports idle, and then raises a ready bit.

While the port is held, three register bits drive the EEPROM chip-select, serial clock and serial data pins directly. A fourth bit returns a synchronised sample of the EEPROM's data output. Software produces every command, address and data bit itself by writing the register.

The ready bit also paces software. The first rise after a request only means that the port was granted. After that, every register write while the port is held clears ready. Ready comes back a fixed number of clock cycles later, set by a parameter, so software can use it as a bit-period timer. Clearing the request bit releases the port and parks the pins low.

Top module: `seeprom_port_arb`

## Requirements
- R1: After reset the register reads 0x00, the grant output is low and all three EEPROM output pins are low.
- R2: Take a write that sets the request bit (bit 5) while the port is not held and `mem_busy_i` is low. The grant and ready appear one clock edge after the write edge, not at the write edge.
- R3: The grant never rises on an edge where `mem_busy_i` is high. It rises on the first edge with the request bit stored and `mem_busy_i` low.
- R4: Ready (bit 4) rises on the same edge as the grant, with no pacing delay.
- R5: Take a register write while the port is held that keeps the request bit set. Ready is 0 after that write edge and stays 0 for DELAY_CYC-1 further edges. It is 1 after exactly DELAY_CYC edges.
- R6: A write made while the pacing delay is still running restarts the full DELAY_CYC window from the new write edge.
- R7: A write that clears the request bit drops the grant, ready and all three output pins at that write edge.
- R8: While the port is held, `ee_cs_o`, `ee_clk_o` and `ee_data_o` follow register bits 3, 2 and 1 from the write edge on.
- R9: Bit 0 reads `ee_data_i` after two clock edges of synchronisation while the port is held, and reads 0 while the port is not held.
- R10: While the port is held, `mem_busy_i` has no effect on the grant.
- R11: The read layout is: bit 7 grant, bit 6 a plain software flag, bit 5 request, bit 4 ready, bits 3..1 the stored pin bits, bit 0 the data sample. Write data on bits 7, 4 and 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read value |
| mem_busy_i | input | 1 | Other requester is using the memory port |
| mem_grant_o | output | 1 | Port held for EEPROM access |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_clk_o | output | 1 | EEPROM serial clock |
| ee_data_o | output | 1 | Serial data to the EEPROM |
| ee_data_i | input | 1 | Serial data from the EEPROM |

## Verification
A grant flop in the wrong state shows at once: on the next read, bit 7 and the output pins disagree with the request history, and a grant taken during busy is visible the edge it happens. A wrong pacing counter changes the edge on which ready returns after a held-port write, so the bench looks at ready in the cycle just before and just after the expected DELAY_CYC boundary. A fault in the synchroniser or the gating of the input bit shows within two edges of a change on `ee_data_i`, or as a stray 1 while the port is released.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int unsigned BIT_GNT  = 7;
  localparam int unsigned BIT_FLAG = 6;
  localparam int unsigned BIT_REQ  = 5;
  localparam int unsigned BIT_RDY  = 4;
  localparam int unsigned BIT_CS   = 3;
  localparam int unsigned BIT_CLK  = 2;
  localparam int unsigned BIT_DOUT = 1;
  localparam int unsigned BIT_DIN  = 0;
  localparam int unsigned REG_W    = 8;
endpackage

// File: rtl/seeprom_sync.sv
module seeprom_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[g] <= 1'b0;
      else if (g == 0) stg_q[g] <= d_i;
      else stg_q[g] <= stg_q[(g == 0) ? 0 : g-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/seeprom_grant.sv
module seeprom_grant (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_q_i,
  input  logic we_i,
  input  logic wreq_i,
  input  logic busy_i,
  output logic grant_o,
  output logic rise_o,
  output logic release_o
);
  logic grant_q;

  assign release_o = grant_q & we_i & ~wreq_i;
  assign rise_o    = ~grant_q & req_q_i & ~busy_i & ~(we_i & ~wreq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        grant_q <= 1'b0;
    else if (release_o) grant_q <= 1'b0;
    else if (rise_o)    grant_q <= 1'b1;
  end

  assign grant_o = grant_q;

  // R3
  no_grant_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!grant_q && busy_i) |=> !grant_q);

  // R7
  release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_q && we_i && !wreq_i) |=> !grant_q);

  // R10
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_q && !we_i) |=> grant_q);
endmodule

// File: rtl/seeprom_pace_timer.sv
module seeprom_pace_timer #(
  parameter int unsigned DELAY_CYC = 80
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic set_i,
  input  logic load_i,
  output logic rdy_o
);
  localparam int unsigned CW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);
  localparam logic [CW-1:0] LOAD_V = CW'(DELAY_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          rdy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      rdy_q <= 1'b0;
    end else if (set_i) begin
      rdy_q <= 1'b1;
    end else if (load_i) begin
      cnt_q <= LOAD_V;
      rdy_q <= 1'b0;
    end else if (!rdy_q) begin
      if (cnt_q == '0) rdy_q <= 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign rdy_o = rdy_q;

  // R4
  rdy_on_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clear_i) |=> rdy_o);

  // R5
  load_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !clear_i && !set_i) |=> !rdy_o);
endmodule

// File: rtl/seeprom_port_arb.sv
module seeprom_port_arb
  import seeprom_pkg::*;
#(
  parameter int unsigned DELAY_CYC   = 80,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [REG_W-1:0] reg_wdata_i,
  output logic [REG_W-1:0] reg_rdata_o,
  input  logic             mem_busy_i,
  output logic             mem_grant_o,
  output logic             ee_cs_o,
  output logic             ee_clk_o,
  output logic             ee_data_o,
  input  logic             ee_data_i
);
  logic flag_q, req_q, cs_q, clk_q, dout_q;
  logic grant, g_rise, g_rel, rdy, din_s, load;
  logic unused_wbits;

  assign unused_wbits = ^{reg_wdata_i[BIT_GNT], reg_wdata_i[BIT_RDY], reg_wdata_i[BIT_DIN]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {flag_q, req_q, cs_q, clk_q, dout_q} <= '0;
    end else if (reg_we_i) begin
      flag_q <= reg_wdata_i[BIT_FLAG];
      req_q  <= reg_wdata_i[BIT_REQ];
      cs_q   <= reg_wdata_i[BIT_CS];
      clk_q  <= reg_wdata_i[BIT_CLK];
      dout_q <= reg_wdata_i[BIT_DOUT];
    end
  end

  seeprom_grant i_grant (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_q_i   (req_q),
    .we_i      (reg_we_i),
    .wreq_i    (reg_wdata_i[BIT_REQ]),
    .busy_i    (mem_busy_i),
    .grant_o   (grant),
    .rise_o    (g_rise),
    .release_o (g_rel)
  );

  // pacing only arms on a held port whose request stays set
  assign load = reg_we_i & grant & reg_wdata_i[BIT_REQ];

  seeprom_pace_timer #(.DELAY_CYC(DELAY_CYC)) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (g_rel | (~grant & ~g_rise)),
    .set_i   (g_rise),
    .load_i  (load),
    .rdy_o   (rdy)
  );

  seeprom_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ee_data_i),
    .q_o    (din_s)
  );

  assign mem_grant_o = grant;
  assign ee_cs_o     = grant & cs_q;
  assign ee_clk_o    = grant & clk_q;
  assign ee_data_o   = grant & dout_q;

  always_comb begin
    reg_rdata_o           = '0;
    reg_rdata_o[BIT_GNT]  = grant;
    reg_rdata_o[BIT_FLAG] = flag_q;
    reg_rdata_o[BIT_REQ]  = req_q;
    reg_rdata_o[BIT_RDY]  = rdy;
    reg_rdata_o[BIT_CS]   = cs_q;
    reg_rdata_o[BIT_CLK]  = clk_q;
    reg_rdata_o[BIT_DOUT] = dout_q;
    reg_rdata_o[BIT_DIN]  = grant & din_s;
  end

  // independent count of edges since the last write
  localparam int unsigned SW = $clog2(DELAY_CYC + 2);
  logic [SW-1:0] since_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          since_wr_q <= '1;
    else if (reg_we_i)                    since_wr_q <= '0;
    else if (since_wr_q != SW'(DELAY_CYC + 1)) since_wr_q <= since_wr_q + 1'b1;
  end

  // R5
  pace_window_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant && !reg_we_i && !rdy && since_wr_q == SW'(DELAY_CYC - 1)) |=> rdy);

  // R6
  pace_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant && !rdy && since_wr_q < SW'(DELAY_CYC - 1) && !reg_we_i) |=> !rdy);

  // R7
  pins_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_q) |-> (!ee_cs_o && !ee_clk_o && !ee_data_o && !mem_grant_o));
endmodule

// File: tb/test_seeprom_port_arb.sv
module test_seeprom_port_arb;
  localparam int unsigned D = 80;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy = 1'b0;
  logic       grant, cs, sk, dout;
  logic       din = 1'b0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  seeprom_port_arb #(.DELAY_CYC(D)) i_seeprom_port_arb (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .mem_busy_i(busy), .mem_grant_o(grant),
    .ee_cs_o(cs), .ee_clk_o(sk), .ee_data_o(dout), .ee_data_i(din)
  );

  function automatic logic [7:0] exp_rd(input logic g, input logic [7:0] w,
                                        input logic r, input logic s);
    return {g, w[6], w[5], r, w[3], w[2], w[1], g & s};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] w;
    wait_n(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 rdata", rdata, 8'h00);
    chk("R1 pins", {grant, cs, sk, dout}, 4'b0000);

    // R3 busy holds off grant
    busy = 1'b1;
    wr(8'h20);
    chk("R3 no grant while busy", grant, 1'b0);
    wait_n(5);
    chk("R3 still held off", rdata, exp_rd(1'b0, 8'h20, 1'b0, 1'b0));
    busy = 1'b0;
    @(negedge clk);
    chk("R3 grant after busy", grant, 1'b1);
    // R4 ready with grant, R11 layout
    chk("R4 ready on grant", rdata, 8'hB0);

    // R5 pacing, R10 busy ignored
    busy = 1'b1;
    wr(8'h28);
    chk("R5 ready low after write", rdata, 8'hA8);
    chk("R8 cs follows", {cs, sk, dout}, 3'b100);
    wait_n(D - 1);
    chk("R5 ready low at D-1", rdata[4], 1'b0);
    chk("R10 grant kept under busy", grant, 1'b1);
    @(negedge clk);
    chk("R5 ready high at D", rdata[4], 1'b1);

    // R6 restart
    wr(8'h2C);
    wait_n(40);
    wr(8'h28);
    wait_n(D - 1);
    chk("R6 restart low at D-1", rdata[4], 1'b0);
    @(negedge clk);
    chk("R6 restart high at D", rdata[4], 1'b1);

    // R11 read-only bits ignored
    wr(8'hF1);
    chk("R11 ro bits", rdata, 8'hE0);

    // R9 data-in sync
    din = 1'b1;
    @(negedge clk);
    chk("R9 one edge", rdata[0], 1'b0);
    @(negedge clk);
    chk("R9 two edges", rdata[0], 1'b1);

    // R8 / R10 random pin patterns with random busy
    for (int i = 0; i < 30; i++) begin
      busy = 1'($urandom);
      w = {1'b0, 1'($urandom), 1'b1, 1'b0, 3'($urandom), 1'b0};
      wr(w);
      chk("R8 pins", {cs, sk, dout}, w[3:1]);
      chk("R10 grant", grant, 1'b1);
      chk("R11 readback", rdata, exp_rd(1'b1, w, 1'b0, 1'b1));
    end
    busy = 1'b0;

    // R7 release, R9 gated
    wr(8'h08);
    chk("R7 released", {grant, cs, sk, dout}, 4'b0000);
    chk("R9 gated din", rdata, 8'h08);

    // R2 re-request
    wr(8'h20);
    chk("R2 no grant at write edge", grant, 1'b0);
    @(negedge clk);
    chk("R2 grant next edge", grant, 1'b1);
    chk("R4 ready immediate", rdata[4], 1'b1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < 20000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule